// File: doc/BRIEF.md
# Indirect read buffer with watermark

This block sits between a serial flash reader and a host register port during a host-initiated read. The host first programs a start address and a byte count into their own registers, then writes the start bit of the control register. From then on, a byte-stream producer on the flash side delivers received bytes through a ready/valid handshake. The block packs those bytes little-endian into 32-bit words and stores them in an internal word FIFO. The host drains the FIFO one word per read of the data register.

The host can see the fill level, counted in FIFO words. Four sticky status bits are kept: watermark reached, buffer full, transfer complete and read underflow. Each bit is cleared by writing 1 to it. A mask register combines the status bits into one interrupt line. A cancel write aborts the transfer at any point and empties the buffer. When the FIFO is full the producer is held off and no bytes are lost. The transfer ends once the host has taken the final word. At that point a sticky done bit is set, and the host clears it by writing it back.

Register map (word index on `reg_addr`): 0 control, 1 start address, 2 byte count, 3 watermark in bytes, 4 fill level, 5 interrupt status, 6 interrupt mask, 7 data (a read pops one word).

Top module: `ird_buffer`

## Requirements
- R1: After reset, the control reads 0, the fill level reads 0, the watermark reads DEPTH_WORDS*2 bytes and the status reads 0. `irq`, `fl_ready` and `xfer_busy` are all 0.
- R2: A control write with bit 0 set and bit 1 clear, made while idle with a non-zero byte count, starts a transfer. `xfer_busy` and control bit 2 then read 1, `xfer_addr` shows the programmed start address, and `fl_ready` rises.
- R3: Stream byte j of a transfer appears in data word floor(j/4) at bits [8*(j mod 4)+7 : 8*(j mod 4)]. Words are returned in arrival order.
- R4: When the count is not a multiple of 4, the last word holds the remaining bytes in its low lanes and zero in the unused high lanes.
- R5: Register 4 bits [15:0] give the number of occupied FIFO words. The value equals the words completed by the producer minus the words popped by the host.
- R6: While the FIFO holds DEPTH_WORDS words, `fl_ready` is 0 and status bit 12 (full) is set. No byte is dropped: every byte later reaches the host in order.
- R7: Status bit 6 (watermark) is set while 4 times the fill level is at least the watermark register and the level is non-zero. Below that threshold the bit stays clear once cleared.
- R8: After exactly the programmed count of bytes has been accepted, intake stops (`fl_ready` 0). When the host pops the final word, busy drops, control bit 5 (done) and status bit 2 (complete) are set, and writing 1 to control bit 5 clears done.
- R9: A data read from an empty FIFO returns 0 and sets status bit 1 (underflow).
- R10: Writing 1 to a status bit clears it. If its set condition holds in the same cycle, the set wins.
- R11: `irq` is 1 exactly when some status bit is set whose bit at the same position in the mask register (register 6) is also set.
- R12: A control write with bit 1 set aborts the transfer. The level becomes 0, busy drops, `fl_ready` goes to 0 and done is not set.
- R13: A word completed by the producer in the same cycle as a host pop leaves the fill level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on data register) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the strobe cycle |
| fl_valid | input | 1 | Producer byte valid |
| fl_data | input | 8 | Producer byte |
| fl_ready | output | 1 | Block accepts a byte |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_addr | output | ADDR_W | Programmed flash start address |
| irq | output | 1 | Masked interrupt |

## Verification
The producer handshake and the host pop can complete in the same cycle. In that cycle the FIFO takes a word in and gives a word out, and the level must not move. The bench keeps the producer valid on a random three-cycles-in-four pattern while the host polls the level and reads the data register. This makes a word completion coincide with a pop many times, and each such cycle is counted. Each level read is compared with a model built from the handshakes and pops the bench observed. A second collision is a status clear meeting a condition that still holds. This is forced by clearing the watermark bit while the level stays above the threshold, and the bit is expected to remain set.

// File: rtl/ird_buffer.sv
module ird_buffer #(
  parameter int DEPTH_WORDS = 16,
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              fl_valid,
  input  logic [7:0]        fl_data,
  output logic              fl_ready,
  output logic              xfer_busy,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic              irq
);
  localparam int PW = $clog2(DEPTH_WORDS);
  localparam int LW = PW + 1;
  localparam logic [CNT_W-1:0] WM_RST = CNT_W'(DEPTH_WORDS * 2);
  localparam logic [LW-1:0] FULL = LW'(DEPTH_WORDS);

  logic [31:0]       mem [DEPTH_WORDS];
  logic [PW-1:0]     wptr_q, rptr_q;
  logic [LW-1:0]     cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  count_q, wmark_q, in_left_q, out_left_q;
  logic [1:0]        bidx_q;
  logic [31:0]       pack_q, word_in;
  logic              busy_q, done_q;
  logic              st_unf, st_cmp, st_wm, st_full;
  logic [3:0]        imask_q;

  wire wr_ctrl    = reg_wr && reg_addr == 3'd0;
  wire wr_ist     = reg_wr && reg_addr == 3'd5;
  wire cancel_req = wr_ctrl && reg_wdata[1];
  wire start_req  = wr_ctrl && reg_wdata[0] && !reg_wdata[1] && !busy_q && count_q != '0;
  wire rd_data    = reg_rd && reg_addr == 3'd7;
  wire pop        = rd_data && cnt_q != '0;
  wire under      = rd_data && cnt_q == '0;
  wire push_byte  = fl_valid && fl_ready;
  wire word_done  = push_byte && (bidx_q == 2'd3 || in_left_q == CNT_W'(1));
  wire last_pop   = pop && out_left_q <= CNT_W'(4);
  wire [LW+1:0] lvl_bytes = {cnt_q, 2'b00};
  wire set_wm     = cnt_q != '0 && (CNT_W+LW+2)'(lvl_bytes) >= (CNT_W+LW+2)'(wmark_q);
  wire set_full   = cnt_q == FULL;
  wire [31:0] ist_view = 32'({st_full, 5'b0, st_wm, 3'b0, st_cmp, st_unf, 1'b0});
  wire [31:0] msk_view = 32'({imask_q[3], 5'b0, imask_q[2], 3'b0, imask_q[1], imask_q[0], 1'b0});

  assign fl_ready  = busy_q && in_left_q != '0 && cnt_q != FULL;
  assign xfer_busy = busy_q;
  assign xfer_addr = addr_q;
  assign irq       = |(ist_view & msk_view);

  always_comb begin
    word_in = pack_q;
    word_in[bidx_q*8 +: 8] = fl_data;
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {26'b0, done_q, 2'b0, busy_q, 2'b0};
      3'd1:    reg_rdata = 32'(addr_q);
      3'd2:    reg_rdata = 32'(count_q);
      3'd3:    reg_rdata = 32'(wmark_q);
      3'd4:    reg_rdata = 32'(cnt_q);
      3'd5:    reg_rdata = ist_view;
      3'd6:    reg_rdata = msk_view;
      default: reg_rdata = (cnt_q != '0) ? mem[rptr_q] : 32'b0;
    endcase
  end

  always_ff @(posedge clk)
    if (word_done && !cancel_req) mem[wptr_q] <= word_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      count_q <= '0;
      wmark_q <= WM_RST;
      imask_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd1: addr_q  <= reg_wdata[ADDR_W-1:0];
        3'd2: count_q <= reg_wdata[CNT_W-1:0];
        3'd3: wmark_q <= reg_wdata[CNT_W-1:0];
        3'd6: imask_q <= {reg_wdata[12], reg_wdata[6], reg_wdata[2], reg_wdata[1]};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0;
      wptr_q <= '0; rptr_q <= '0; cnt_q <= '0;
      bidx_q <= '0; pack_q <= '0;
      in_left_q <= '0; out_left_q <= '0;
    end else if (cancel_req) begin
      busy_q <= 1'b0;
      done_q <= done_q & ~reg_wdata[5];
      wptr_q <= '0; rptr_q <= '0; cnt_q <= '0;
      bidx_q <= '0; pack_q <= '0;
      in_left_q <= '0; out_left_q <= '0;
    end else begin
      if (start_req) begin
        busy_q     <= 1'b1;
        in_left_q  <= count_q;
        out_left_q <= count_q;
        bidx_q     <= '0;
        pack_q     <= '0;
      end else begin
        if (push_byte) begin
          in_left_q <= in_left_q - 1'b1;
          bidx_q    <= word_done ? 2'd0 : bidx_q + 1'b1;
          pack_q    <= word_done ? 32'b0 : word_in;
        end
        if (pop) out_left_q <= last_pop ? '0 : out_left_q - CNT_W'(4);
        if (last_pop) busy_q <= 1'b0;
      end
      if (word_done) wptr_q <= wptr_q + 1'b1;
      if (pop) rptr_q <= rptr_q + 1'b1;
      cnt_q  <= cnt_q + LW'(word_done) - LW'(pop);
      done_q <= last_pop | (done_q & ~(wr_ctrl & reg_wdata[5]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_unf <= 1'b0; st_cmp <= 1'b0; st_wm <= 1'b0; st_full <= 1'b0;
    end else begin
      st_unf  <= under    | (st_unf  & ~(wr_ist & reg_wdata[1]));
      st_cmp  <= (last_pop && !cancel_req) | (st_cmp & ~(wr_ist & reg_wdata[2]));
      st_wm   <= set_wm   | (st_wm   & ~(wr_ist & reg_wdata[6]));
      st_full <= set_full | (st_full & ~(wr_ist & reg_wdata[12]));
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  p_stall_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == FULL |-> !fl_ready);
  p_idle_no_intake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !fl_ready);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> !busy_q && st_cmp);
  p_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    under |=> st_unf);
  p_cancel_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_req |=> cnt_q == '0 && !busy_q && !fl_ready);
  p_level_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && pop && !cancel_req) |=> $stable(cnt_q));
endmodule

// File: tb/ird_buffer_tb.sv
module ird_buffer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic fl_valid = 0, fl_ready;
  logic [7:0] fl_data = 0;
  logic xfer_busy, irq;
  logic [31:0] xfer_addr;

  int checks = 0, errors = 0;
  int sent = 0, popped = 0, xcount = 0, coincide = 0;
  bit prod_on = 0;
  logic [7:0] salt = 0;
  logic [31:0] snap_rdata;
  int snap_level;

  ird_buffer #(.DEPTH_WORDS(DEPTH), .CNT_W(16), .ADDR_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fl_valid(fl_valid), .fl_data(fl_data),
    .fl_ready(fl_ready), .xfer_busy(xfer_busy), .xfer_addr(xfer_addr), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] sbyte(int j);
    return 8'((j * 29) + salt);
  endfunction

  function automatic logic [31:0] ew(int k, int n);
    logic [31:0] w = 0;
    for (int i = 0; i < 4; i++)
      if (4*k + i < n) w[8*i +: 8] = sbyte(4*k + i);
    return w;
  endfunction

  function automatic int pushed(int s, int n);
    return (n > 0 && s == n) ? (s + 3) / 4 : s / 4;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    bit hs, isdata;
    fl_valid = prod_on && ($urandom_range(0, 3) != 0);
    fl_data  = sbyte(sent);
    #1;
    snap_rdata = reg_rdata;
    snap_level = pushed(sent, xcount) - popped;
    hs = fl_valid && fl_ready;
    isdata = reg_rd && reg_addr == 3'd7;
    if (isdata && snap_level > 0) begin
      popped++;
      if (hs && ((sent % 4) == 3 || sent + 1 == xcount)) coincide++;
    end
    if (hs) sent++;
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    cyc();
    reg_rd = 0;
    d = snap_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic setup(int n);
    logic [31:0] a, v;
    a = $urandom;
    xcount = n; sent = 0; popped = 0; salt = 8'($urandom);
    wr(3'd1, a);
    wr(3'd2, n);
    wr(3'd0, 32'h1);
    prod_on = 1;
    chk("R2 busy", {31'b0, xfer_busy}, 1);
    chk("R2 start address", xfer_addr, a);
    rd(3'd0, v);
    chk("R2 control busy bit", v & 32'h4, 32'h4);
  endtask

  task automatic drain(int n);
    logic [31:0] lv, d;
    int k = 0, guard = 0;
    while (k < (n + 3) / 4 && guard < 20000) begin
      guard++;
      rd(3'd4, lv);
      chk("R5 level", lv, snap_level);
      if (lv != 0 && $urandom_range(0, 2) != 0) begin
        rd(3'd7, d);
        chk((4*k + 4 > n) ? "R4 padded last word" : "R3 packed word", d, ew(k, n));
        k++;
      end
    end
  endtask

  task automatic finish_xfer(int n);
    logic [31:0] v;
    idle(3);
    chk("R8 bytes accepted", sent, n);
    chk("R8 intake stopped", {31'b0, fl_ready}, 0);
    rd(3'd0, v);
    chk("R8 done set, idle", v, 32'h20);
    rd(3'd5, v);
    chk("R8 complete status", v & 32'h4, 32'h4);
    wr(3'd5, 32'h1046);
    wr(3'd0, 32'h20);
    rd(3'd0, v);
    chk("R8 done cleared", v, 0);
    prod_on = 0;
  endtask

  task automatic run_xfer(int n);
    setup(n); drain(n); finish_xfer(n);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int g;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(3'd0, v); chk("R1 control", v, 0);
    rd(3'd4, v); chk("R1 level", v, 0);
    rd(3'd3, v); chk("R1 watermark", v, DEPTH * 2);
    rd(3'd5, v); chk("R1 status", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 ready", {31'b0, fl_ready}, 0);
    chk("R1 busy", {31'b0, xfer_busy}, 0);

    rd(3'd7, v); chk("R9 empty read", v, 0);
    rd(3'd5, v); chk("R9 underflow", v, 32'h2);
    wr(3'd6, 32'h4);
    chk("R11 unmasked bit", {31'b0, irq}, 0);
    wr(3'd6, 32'h2);
    chk("R11 masked bit", {31'b0, irq}, 1);
    wr(3'd5, 32'h2);
    rd(3'd5, v); chk("R10 clear", v, 0);
    chk("R11 irq after clear", {31'b0, irq}, 0);
    wr(3'd6, 32'h0);

    run_xfer(10);
    run_xfer(8);
    run_xfer(1);

    setup(40);
    g = 0;
    while (sent < DEPTH * 4 && g < 2000) begin cyc(); g++; end
    idle(5);
    chk("R6 stall", {31'b0, fl_ready}, 0);
    chk("R6 no extra byte", sent, DEPTH * 4);
    rd(3'd4, v); chk("R6 level full", v, DEPTH);
    rd(3'd5, v); chk("R6 full status", v & 32'h1000, 32'h1000);
    chk("R7 watermark at full", v & 32'h40, 32'h40);
    drain(40); finish_xfer(40);

    wr(3'd3, 12);
    setup(12);
    g = 0;
    while (sent < 12 && g < 2000) begin cyc(); g++; end
    idle(2);
    wr(3'd5, 32'h40);
    rd(3'd5, v); chk("R10 set wins over clear", v & 32'h40, 32'h40);
    wr(3'd3, 16);
    wr(3'd5, 32'h40);
    rd(3'd5, v); chk("R7 below threshold", v & 32'h40, 0);
    drain(12); finish_xfer(12);

    setup(20);
    g = 0;
    while (sent < 6 && g < 2000) begin cyc(); g++; end
    wr(3'd0, 32'h2);
    prod_on = 0; xcount = 0; sent = 0; popped = 0;
    rd(3'd4, v); chk("R12 level emptied", v, 0);
    rd(3'd0, v); chk("R12 idle, no done", v, 0);
    chk("R12 ready low", {31'b0, fl_ready}, 0);
    wr(3'd5, 32'h1046);

    for (int t = 0; t < 6; t++) run_xfer($urandom_range(1, 45));

    checks++;
    if (coincide == 0) begin
      errors++;
      $display("FAIL R13: actual %0d coincident cycles expected >0", coincide);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule